// File: doc/BRIEF.md
# Cascaded Conversion-Rate Timing Generator

This block derives every sampling instant of a two-direction data converter front end from a single master clock. Each direction has its own pair of cascaded down-counters. The first stage divides the master clock into a filter-clock enable. The second stage divides that enable into a conversion strobe. One direction drives the output (D/A) side and the other drives the input (A/D) side. All outputs are single-cycle enables in the master clock domain, apart from a square-wave serial shift clock at one quarter of the master rate.

The reload values arrive on plain input ports and are sampled only at reload. A value that changes part-way through a period therefore never cuts that period short. A one-shot adjust request stretches or shortens the next first-stage period by a delta, which moves the conversion instant later or earlier by exactly that many master cycles. When the synchronous mode input is high, the receive outputs copy the transmit timing, and the receive reload inputs and adjust request have no effect.

Top module: `conv_rate_timer`

## Requirements
- R1: `sclk` is low for the first two master cycles after reset and is then high for two cycles and low for two, in a repeating pattern. In cycle k after reset release it equals 1 exactly when k mod 4 is 2 or 3.
- R2: With a first-stage length N, `*_fclk` is a one-cycle pulse in cycles N, 2N, 3N and so on, counting the first clock edge after reset release as cycle 1. All outputs are 0 during reset.
- R3: With a second-stage length M, `*_conv` pulses together with every M-th filter-clock pulse, first in cycle N*M. It never pulses without `*_fclk`.
- R4: A request with `*_adj_late`=0 captured before a first-stage reload makes the next first-stage period N-D long, where D is the delta. Later periods return to N, so every later conversion comes D cycles earlier.
- R5: A request with `*_adj_late`=1 makes the next first-stage period N+D long, then reverts to N, so the conversions come D cycles later.
- R6: A first-stage length (base, base-D or base+D) below 2 is replaced by 2. A base-D that would go negative also gives 2. A second-stage length of 0 acts as 1.
- R7: A change of `*_base` takes effect only at the next first-stage reload.
- R8: A change of `*_div` takes effect only at the reload that follows the next conversion strobe.
- R9: The receive path runs from its own inputs and is independent of the transmit settings when `sync_mode`=0.
- R10: While `sync_mode`=1, `rx_fclk` and `rx_conv` equal `tx_fclk` and `tx_conv`, and the `rx_*` reload and adjust inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1: receive timing follows the transmit counters |
| tx_base | input | A_W | Transmit first-stage length N |
| tx_delta | input | A_W | Transmit adjust amount D |
| tx_div | input | B_W | Transmit second-stage length M |
| tx_adj_req | input | 1 | One-cycle request to adjust the next transmit first-stage period |
| tx_adj_late | input | 1 | 1: lengthen (retard), 0: shorten (advance) |
| rx_base | input | A_W | Receive first-stage length |
| rx_delta | input | A_W | Receive adjust amount |
| rx_div | input | B_W | Receive second-stage length |
| rx_adj_req | input | 1 | One-cycle request to adjust the next receive first-stage period |
| rx_adj_late | input | 1 | 1: lengthen, 0: shorten |
| sclk | output | 1 | Shift clock, master frequency / 4 |
| tx_fclk | output | 1 | Transmit filter-clock enable pulse |
| tx_conv | output | 1 | Transmit conversion strobe |
| rx_fclk | output | 1 | Receive filter-clock enable pulse |
| rx_conv | output | 1 | Receive conversion strobe |

## Verification
On every cycle the assertions check local invariants. A conversion strobe never appears without a filter-clock pulse. Filter pulses never come on back-to-back cycles. A first-stage reload never loads a length below the floor. A pending adjust is consumed by the reload that uses it. The shift clock holds each level for at least two cycles. Only the bench scenarios can show exact pulse positions: the arithmetic N and N*M spacing, the D-cycle advance and retard, deferred reload changes, clamping, and the transmit timing copied in synchronous mode.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_EARLY = 2'd1,
    ADJ_LATE  = 2'd2
  } adj_e;

  localparam int MIN_A_LEN = 2;
  localparam int MIN_B_LEN = 1;
endpackage

// File: rtl/ct_sclk.sv
module ct_sclk #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst,
  output logic sclk
);
  localparam int PW = DIV_LOG2;

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  assign sclk = phase[PW-1];

  p_sclk_hold_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |=> sclk);
  p_sclk_low_hold_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |=> !sclk);
endmodule

// File: rtl/ct_cascade.sv
module ct_cascade
  import ct_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] delta,
  input  logic [BW-1:0] div,
  input  logic          adj_req,
  input  logic          adj_late,
  output logic          fclk,
  output logic          conv
);
  localparam int EW = AW + 1;

  logic [EW-1:0] a_cnt;
  logic [BW-1:0] b_cnt;
  logic          pend;
  logic          pend_late;
  logic          a_term;
  logic          b_term;
  adj_e          mode;
  logic [EW-1:0] plain_len;
  logic [EW-1:0] sel_len;
  logic [BW-1:0] b_len;

  function automatic logic [EW-1:0] first_len(input logic [AW-1:0] b,
                                              input logic [AW-1:0] d,
                                              input adj_e m);
    logic [EW-1:0] v;
    case (m)
      ADJ_EARLY: v = (d >= b) ? '0 : (EW'(b) - EW'(d));
      ADJ_LATE:  v = EW'(b) + EW'(d);
      default:   v = EW'(b);
    endcase
    if (v < EW'(MIN_A_LEN)) v = EW'(MIN_A_LEN);
    return v;
  endfunction

  assign a_term    = (a_cnt == '0);
  assign b_term    = (b_cnt == '0);
  assign mode      = pend ? (pend_late ? ADJ_LATE : ADJ_EARLY) : ADJ_NONE;
  assign plain_len = first_len(base, delta, ADJ_NONE);
  assign sel_len   = first_len(base, delta, mode);
  assign b_len     = (div == '0) ? BW'(MIN_B_LEN) : div;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cnt <= plain_len - 1'b1;
      b_cnt <= b_len - 1'b1;
      fclk  <= 1'b0;
      conv  <= 1'b0;
    end else begin
      fclk <= a_term;
      conv <= a_term && b_term;
      if (a_term) begin
        a_cnt <= sel_len - 1'b1;
        b_cnt <= b_term ? (b_len - 1'b1) : (b_cnt - 1'b1);
      end else begin
        a_cnt <= a_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_late <= 1'b0;
    end else if (adj_req) begin
      pend      <= 1'b1;
      pend_late <= adj_late;
    end else if (a_term) begin
      pend      <= 1'b0;
    end
  end

  p_conv_on_fclk_r3: assert property (@(posedge clk) disable iff (rst)
    conv |-> fclk);
  p_fclk_single_r2: assert property (@(posedge clk) disable iff (rst)
    fclk |=> !fclk);
  p_reload_floor_r6: assert property (@(posedge clk) disable iff (rst)
    a_term |=> (a_cnt >= EW'(MIN_A_LEN - 1)));
  p_adj_one_shot_r4: assert property (@(posedge clk) disable iff (rst)
    (a_term && pend && !adj_req) |=> !pend);
endmodule

// File: rtl/conv_rate_timer.sv
module conv_rate_timer #(
  parameter int A_W = 8,
  parameter int B_W = 6,
  parameter int SCLK_DIV_LOG2 = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sync_mode,
  input  logic [A_W-1:0] tx_base,
  input  logic [A_W-1:0] tx_delta,
  input  logic [B_W-1:0] tx_div,
  input  logic           tx_adj_req,
  input  logic           tx_adj_late,
  input  logic [A_W-1:0] rx_base,
  input  logic [A_W-1:0] rx_delta,
  input  logic [B_W-1:0] rx_div,
  input  logic           rx_adj_req,
  input  logic           rx_adj_late,
  output logic           sclk,
  output logic           tx_fclk,
  output logic           tx_conv,
  output logic           rx_fclk,
  output logic           rx_conv
);
  logic rx_rst;
  logic rx_fclk_own;
  logic rx_conv_own;

  assign rx_rst = rst || sync_mode;

  ct_sclk #(.DIV_LOG2(SCLK_DIV_LOG2)) u_sclk (
    .clk (clk),
    .rst (rst),
    .sclk(sclk)
  );

  ct_cascade #(.AW(A_W), .BW(B_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .base    (tx_base),
    .delta   (tx_delta),
    .div     (tx_div),
    .adj_req (tx_adj_req),
    .adj_late(tx_adj_late),
    .fclk    (tx_fclk),
    .conv    (tx_conv)
  );

  ct_cascade #(.AW(A_W), .BW(B_W)) u_rx (
    .clk     (clk),
    .rst     (rx_rst),
    .base    (rx_base),
    .delta   (rx_delta),
    .div     (rx_div),
    .adj_req (rx_adj_req),
    .adj_late(rx_adj_late),
    .fclk    (rx_fclk_own),
    .conv    (rx_conv_own)
  );

  assign rx_fclk = sync_mode ? tx_fclk : rx_fclk_own;
  assign rx_conv = sync_mode ? tx_conv : rx_conv_own;
endmodule

// File: tb/test_conv_rate_timer.sv
module test_conv_rate_timer;
  localparam int A_W = 8;
  localparam int B_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_mode = 1'b0;
  logic [A_W-1:0] tx_base = 8'd3, tx_delta = 8'd0, rx_base = 8'd5, rx_delta = 8'd0;
  logic [B_W-1:0] tx_div = 6'd2, rx_div = 6'd2;
  logic tx_adj_req = 1'b0, tx_adj_late = 1'b0, rx_adj_req = 1'b0, rx_adj_late = 1'b0;
  logic sclk, tx_fclk, tx_conv, rx_fclk, rx_conv;

  always #10 clk = ~clk;

  conv_rate_timer #(.A_W(A_W), .B_W(B_W)) i_conv_rate_timer (
    .clk(clk), .rst(rst), .sync_mode(sync_mode),
    .tx_base(tx_base), .tx_delta(tx_delta), .tx_div(tx_div),
    .tx_adj_req(tx_adj_req), .tx_adj_late(tx_adj_late),
    .rx_base(rx_base), .rx_delta(rx_delta), .rx_div(rx_div),
    .rx_adj_req(rx_adj_req), .rx_adj_late(rx_adj_late),
    .sclk(sclk), .tx_fclk(tx_fclk), .tx_conv(tx_conv),
    .rx_fclk(rx_fclk), .rx_conv(rx_conv)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int cyc = 0;
  int gtf[64], gtc[64], grf[64], grc[64];
  int ngtf = 0, ngtc = 0, ngrf = 0, ngrc = 0;
  int ef[64], ec[64];
  int nef = 0, nec = 0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_fclk && ngtf < 64) begin gtf[ngtf] = cyc; ngtf++; end
      if (tx_conv && ngtc < 64) begin gtc[ngtc] = cyc; ngtc++; end
      if (rx_fclk && ngrf < 64) begin grf[ngrf] = cyc; ngrf++; end
      if (rx_conv && ngrc < 64) begin grc[ngrc] = cyc; ngrc++; end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ngtf = 0; ngtc = 0; ngrf = 0; ngrc = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // Expected pulse times: first-stage periods (first, then rest, one index overridden),
  // conversion on the mfirst-th pulse, then every mrest-th pulse.
  task automatic make_exp(input int first, input int rest, input int adj_idx,
                          input int adj_len, input int mfirst, input int mrest,
                          input int limit);
    int t = 0;
    int i = 0;
    int cnt = 0;
    int need = mfirst;
    int len;
    nef = 0; nec = 0;
    while (1) begin
      len = (i == 0) ? first : rest;
      if (i == adj_idx) len = adj_len;
      t += len;
      if (t > limit || nef >= 64) break;
      ef[nef] = t; nef++;
      cnt++;
      if (cnt == need) begin
        ec[nec] = t; nec++;
        cnt = 0;
        need = mrest;
      end
      i++;
    end
  endtask

  task automatic cmp(input string tag, input int sel);
    int g[64];
    int gn;
    int e[64];
    int en;
    int bad = -1;
    case (sel)
      0: begin g = gtf; gn = ngtf; e = ef; en = nef; end
      1: begin g = gtc; gn = ngtc; e = ec; en = nec; end
      2: begin g = grf; gn = ngrf; e = ef; en = nef; end
      default: begin g = grc; gn = ngrc; e = ec; en = nec; end
    endcase
    checks++;
    if (gn != en) begin
      fails++;
      $display("FAIL %s: actual %0d pulses expected %0d", tag, gn, en);
    end else begin
      for (int k = 0; k < gn; k++)
        if (bad < 0 && g[k] != e[k]) bad = k;
      if (bad >= 0) begin
        fails++;
        $display("FAIL %s: pulse %0d at cycle %0d expected %0d", tag, bad, g[bad], e[bad]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R2: reset state and R1 shift clock pattern
    tx_base = 8'd3; tx_div = 6'd2; rx_base = 8'd5; rx_div = 6'd2;
    do_reset();
    check_bit("R2 reset tx_fclk", tx_fclk, 1'b0);
    check_bit("R2 reset tx_conv", tx_conv, 1'b0);
    check_bit("R2 reset rx_fclk", rx_fclk, 1'b0);
    check_bit("R2 reset rx_conv", rx_conv, 1'b0);
    check_bit("R1 reset sclk", sclk, 1'b0);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check_bit("R1 sclk", sclk, ((k % 4) >= 2) ? 1'b1 : 1'b0);
    end

    // R2 R3 R9: sweep of small first/second stage lengths, receive independent
    for (int n = 2; n <= 5; n++) begin
      for (int m = 1; m <= 3; m++) begin
        int lim;
        tx_base = A_W'(n); tx_div = B_W'(m);
        rx_base = A_W'(n + 1); rx_div = B_W'(4 - m);
        lim = 3 * (n + 1) * 3 + 1;
        do_reset();
        run(lim);
        make_exp(n, n, -1, 0, m, m, lim);
        cmp("R2 tx_fclk spacing", 0);
        cmp("R3 tx_conv spacing", 1);
        make_exp(n + 1, n + 1, -1, 0, 4 - m, 4 - m, lim);
        cmp("R9 rx_fclk own timing", 2);
        cmp("R9 rx_conv own timing", 3);
      end
    end

    // R4 advance on transmit, R5 retard on receive
    tx_base = 8'd6; tx_delta = 8'd2; tx_div = 6'd2;
    rx_base = 8'd6; rx_delta = 8'd2; rx_div = 6'd2;
    do_reset();
    tx_adj_req = 1'b1; tx_adj_late = 1'b0;
    rx_adj_req = 1'b1; rx_adj_late = 1'b1;
    @(negedge clk);
    tx_adj_req = 1'b0; rx_adj_req = 1'b0;
    run(39);
    make_exp(6, 6, 1, 4, 2, 2, 40);
    cmp("R4 tx_fclk advanced", 0);
    cmp("R4 tx_conv advanced", 1);
    make_exp(6, 6, 1, 8, 2, 2, 40);
    cmp("R5 rx_fclk retarded", 2);
    cmp("R5 rx_conv retarded", 3);

    // R6: base-D negative clamps to 2, base below 2 clamps to 2, div 0 acts as 1
    tx_base = 8'd3; tx_delta = 8'd5; tx_div = 6'd1;
    rx_base = 8'd1; rx_delta = 8'd0; rx_div = 6'd0;
    do_reset();
    tx_adj_req = 1'b1; tx_adj_late = 1'b0;
    @(negedge clk);
    tx_adj_req = 1'b0;
    run(19);
    make_exp(3, 3, 1, 2, 1, 1, 20);
    cmp("R6 tx_fclk clamped advance", 0);
    cmp("R6 tx_conv clamped advance", 1);
    make_exp(2, 2, -1, 0, 1, 1, 20);
    cmp("R6 rx_fclk base floor", 2);
    cmp("R6 rx_conv div zero", 3);

    // R7: base change mid-period; R8: div change deferred to after next conversion
    tx_base = 8'd4; tx_delta = 8'd0; tx_div = 6'd1;
    rx_base = 8'd2; rx_delta = 8'd0; rx_div = 6'd2;
    do_reset();
    @(negedge clk);
    tx_base = 8'd7; rx_div = 6'd3;
    run(29);
    make_exp(4, 7, -1, 0, 1, 1, 30);
    cmp("R7 tx_fclk base deferred", 0);
    make_exp(2, 2, -1, 0, 2, 3, 30);
    cmp("R8 rx_conv div deferred", 3);

    // R10: synchronous mode, receive inputs and adjust ignored
    tx_base = 8'd3; tx_delta = 8'd0; tx_div = 6'd2;
    rx_base = 8'd5; rx_delta = 8'd1; rx_div = 6'd3;
    sync_mode = 1'b1;
    do_reset();
    rx_adj_req = 1'b1; rx_adj_late = 1'b1;
    @(negedge clk);
    rx_adj_req = 1'b0;
    run(24);
    make_exp(3, 3, -1, 0, 2, 2, 25);
    cmp("R10 tx_fclk sync", 0);
    cmp("R10 tx_conv sync", 1);
    cmp("R10 rx_fclk follows tx", 2);
    cmp("R10 rx_conv follows tx", 3);
    sync_mode = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule